// File: doc/BRIEF.md
# Serial Receive Channel Status and Control

This block holds the software-visible state for a group of serial receive channels. Each channel keeps the last byte it received, a buffer-full flag and three error flags (parity, framing, overrun). A bit-level receiver, which is not part of the block, reports each completed character with a one-cycle strobe. The strobe carries the byte and its parity and framing indications. Software reads the received byte and the status over a simple register bus. It clears errors through a write-one-to-clear trigger register, so a status value read earlier can be written back to clear exactly the errors it saw.

Channels are switched on and off through two shared trigger registers, one that starts channels and one that stops them. A third register reports which channels are running. A stopped channel drops every receive strobe. After a framing error, software stops the channel, brings it back into step with the far end, and starts it again.

The bus has a read strobe and a write strobe. Read data is registered and appears one cycle after the read strobe. Bus writes and receive strobes change the state at the clock edge that samples them.

Top module: `uart_rx_status_ctrl`

## Requirements
- R1: After reset all buffer-full and error flags are 0, all stored bytes are 0, every channel is stopped (enable status reads 0) and `bus_rdata` is 0.
- R2: A receive strobe on a running channel stores its byte and sets buffer-full. It also sets the parity flag if `rx_perr` is 1 and the framing flag if `rx_ferr` is 1.
- R3: A bus read of a channel's data register returns the stored byte on `bus_rdata` one cycle after `bus_rd` and clears that channel's buffer-full flag. If a receive strobe arrives in the same cycle as the read, the read returns the old byte, buffer-full stays 1 and no overrun is raised.
- R4: A receive strobe on a running channel whose buffer-full flag is 1, with no data read in the same cycle, sets the overrun flag. The new byte replaces the stored byte.
- R5: The status register places the parity error at bit 0, the framing error at bit 1, the overrun error at bit 2 and buffer-full at bit 3. The upper bits read 0.
- R6: A write to a channel's clear trigger register clears each error flag whose bit (same positions as R5, bits 0 to 2) is 1. It leaves the flags whose bits are 0 unchanged. Bit 3 has no effect on buffer-full.
- R7: Writing back a status value that was read earlier clears only the errors in that value. An error raised after the read stays set.
- R8: When a clear write and a new error for the same flag fall in the same cycle, the flag ends up set.
- R9: Writing 1 to bit n of the start trigger sets channel n's enable status bit. Bits written 0 leave their channels unchanged.
- R10: Writing 1 to bit n of the stop trigger clears channel n's enable status bit. A stop leaves the stored byte and the flags untouched.
- R11: A stopped channel ignores receive strobes: its byte and all its flags stay unchanged.
- R12: Address map. With `bus_addr[4]`=0, `bus_addr[3:2]` picks the channel and `bus_addr[1:0]` picks its register: 0 data, 1 status, 2 clear trigger. With `bus_addr[4]`=1, `bus_addr[1:0]` picks 0 start trigger, 1 stop trigger, 2 enable status (bit n = channel n). The start, stop and clear triggers and every unused offset read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_done | input | NUM_CH | Per-channel one-cycle strobe: a character has completed |
| rx_byte | input | NUM_CH*DATA_W | Received byte for each channel, valid with its strobe |
| rx_perr | input | NUM_CH | Parity error indication, valid with the strobe |
| rx_ferr | input | NUM_CH | Framing error indication, valid with the strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | CH_W+3 | Register address (map in R12) |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, registered, valid one cycle after `bus_rd` |

## Verification
A receive strobe or bus write sampled at clock edge k changes the flags at edge k. A read issued in the next cycle captures them at edge k+1, and the bench checks `bus_rdata` at the falling edge after k+1. Inputs change only on falling edges. A behavioural model sees the same inputs at each rising edge and predicts the registered read data. The bench compares that prediction at every falling edge. Directed reads check hand-computed values for each case: set-over-clear and read-during-receive collisions, write-back clearing, and receive strobes while stopped.

// File: rtl/uart_rxsc_pkg.sv
package uart_rxsc_pkg;

    // Status bit positions
    localparam int ST_PERR = 0;
    localparam int ST_FERR = 1;
    localparam int ST_OVR  = 2;
    localparam int ST_BFF  = 3;
    localparam int ST_W    = 4;
    localparam int ERR_W   = 3;

    // Per-channel register offsets
    localparam logic [1:0] OFF_DATA = 2'd0;
    localparam logic [1:0] OFF_STAT = 2'd1;
    localparam logic [1:0] OFF_CLR  = 2'd2;

    // Shared register offsets
    localparam logic [1:0] OFF_START = 2'd0;
    localparam logic [1:0] OFF_STOP  = 2'd1;
    localparam logic [1:0] OFF_EN    = 2'd2;

    // Packed MSB first: bff lands on bit 3, perr on bit 0
    typedef struct packed {
        logic bff;
        logic ovr;
        logic ferr;
        logic perr;
    } rx_flags_t;

endpackage

// File: rtl/rxsc_chan.sv
module rxsc_chan
    import uart_rxsc_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rx_done,
    input  logic [DATA_W-1:0] rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              data_rd,
    input  logic              clr_wr,
    input  logic [ERR_W-1:0]  clr_mask,
    output logic [DATA_W-1:0] data_o,
    output rx_flags_t         flags_o
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        rx_flags_t         flg;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic     accept;

    always_comb begin
        st_d   = st_q;
        accept = en && rx_done;

        // Clears first, so a same-cycle set overrides them
        if (clr_wr) begin
            if (clr_mask[ST_PERR]) st_d.flg.perr = 1'b0;
            if (clr_mask[ST_FERR]) st_d.flg.ferr = 1'b0;
            if (clr_mask[ST_OVR])  st_d.flg.ovr  = 1'b0;
        end

        if (data_rd) begin
            st_d.flg.bff = 1'b0;
        end

        if (accept) begin
            st_d.data    = rx_byte;
            st_d.flg.bff = 1'b1;
            if (st_q.flg.bff && !data_rd) st_d.flg.ovr  = 1'b1;
            if (rx_perr)                  st_d.flg.perr = 1'b1;
            if (rx_ferr)                  st_d.flg.ferr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign data_o  = st_q.data;
    assign flags_o = st_q.flg;

    // R2
    rx_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_done) |=> (flags_o.bff && data_o == $past(rx_byte)));

    // R3
    bff_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_rd && !(en && rx_done)) |=> !flags_o.bff);

    // R4
    overrun_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_done && flags_o.bff && !data_rd) |=> flags_o.ovr);

    // R6
    perr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && clr_mask[ST_PERR] && !(en && rx_done && rx_perr)) |=> !flags_o.perr);

    // R8
    perr_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && rx_done && rx_perr) |=> flags_o.perr);

    // R11
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !data_rd && !clr_wr) |=> ($stable(data_o) && $stable(flags_o)));

endmodule

// File: rtl/rxsc_enable.sv
module rxsc_enable #(
    parameter int NUM_CH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              stop_wr,
    input  logic [NUM_CH-1:0] mask,
    output logic [NUM_CH-1:0] en_o
);

    typedef struct packed {
        logic [NUM_CH-1:0] en;
    } en_st_t;

    en_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (stop_wr)  st_d.en = st_d.en & ~mask;
        if (start_wr) st_d.en = st_d.en | mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign en_o = st_q.en;

    // R9
    start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> ((en_o & $past(mask)) == $past(mask)));

    // R10
    stop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_wr && !start_wr) |=> ((en_o & $past(mask)) == '0));

    // R9
    enable_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_wr && !stop_wr) |=> $stable(en_o));

endmodule

// File: rtl/rxsc_decode.sv
module rxsc_decode
    import uart_rxsc_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int DATA_W = 8,
    parameter int BUS_W  = 8,
    parameter int CH_W   = 2,
    parameter int ADDR_W = CH_W + 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    input  logic [DATA_W-1:0] ch_data  [NUM_CH],
    input  rx_flags_t         ch_flags [NUM_CH],
    input  logic [NUM_CH-1:0] en,
    output logic [NUM_CH-1:0] data_rd,
    output logic [NUM_CH-1:0] clr_wr,
    output logic [ERR_W-1:0]  clr_mask,
    output logic              start_wr,
    output logic              stop_wr,
    output logic [NUM_CH-1:0] ch_mask,
    output logic [BUS_W-1:0]  bus_rdata
);

    typedef struct packed {
        logic [BUS_W-1:0] rdata;
    } rd_st_t;

    rd_st_t           st_d, st_q;
    logic             glb;
    logic [1:0]       off;
    logic [CH_W-1:0]  ch_idx;
    logic             ch_ok;
    logic [BUS_W-1:0] rd_val;

    initial begin
        assert (BUS_W >= DATA_W && BUS_W >= NUM_CH && BUS_W >= ST_W);
    end

    assign glb      = bus_addr[ADDR_W-1];
    assign off      = bus_addr[1:0];
    assign ch_idx   = bus_addr[CH_W+1:2];
    assign ch_ok    = 32'(ch_idx) < 32'(NUM_CH);
    assign clr_mask = bus_wdata[ERR_W-1:0];
    assign ch_mask  = bus_wdata[NUM_CH-1:0];
    assign start_wr = bus_wr && glb && (off == OFF_START);
    assign stop_wr  = bus_wr && glb && (off == OFF_STOP);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_sel
        logic hit;
        assign hit        = !glb && ch_ok && (32'(ch_idx) == c);
        assign data_rd[c] = bus_rd && hit && (off == OFF_DATA);
        assign clr_wr[c]  = bus_wr && hit && (off == OFF_CLR);
    end

    always_comb begin
        rd_val = '0;
        if (glb) begin
            if (off == OFF_EN) rd_val[NUM_CH-1:0] = en;
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (ch_ok && 32'(ch_idx) == c) begin
                    if (off == OFF_DATA) rd_val[DATA_W-1:0] = ch_data[c];
                    if (off == OFF_STAT) rd_val[ST_W-1:0]   = ch_flags[c];
                end
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (bus_rd) st_d.rdata = rd_val;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bus_rdata = st_q.rdata;

    // R12
    one_data_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(data_rd) && $onehot0(clr_wr));

    // R12
    single_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_wr && stop_wr));

    // R3
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

endmodule

// File: rtl/uart_rx_status_ctrl.sv
module uart_rx_status_ctrl
    import uart_rxsc_pkg::*;
#(
    parameter  int NUM_CH = 4,
    parameter  int DATA_W = 8,
    parameter  int BUS_W  = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int ADDR_W = CH_W + 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        rx_done,
    input  logic [NUM_CH*DATA_W-1:0] rx_byte,
    input  logic [NUM_CH-1:0]        rx_perr,
    input  logic [NUM_CH-1:0]        rx_ferr,
    input  logic                     bus_rd,
    input  logic                     bus_wr,
    input  logic [ADDR_W-1:0]        bus_addr,
    input  logic [BUS_W-1:0]         bus_wdata,
    output logic [BUS_W-1:0]         bus_rdata
);

    logic [NUM_CH-1:0] en;
    logic [NUM_CH-1:0] data_rd;
    logic [NUM_CH-1:0] clr_wr;
    logic [ERR_W-1:0]  clr_mask;
    logic              start_wr;
    logic              stop_wr;
    logic [NUM_CH-1:0] ch_mask;
    logic [DATA_W-1:0] ch_data  [NUM_CH];
    rx_flags_t         ch_flags [NUM_CH];

    rxsc_decode #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .BUS_W  (BUS_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .ch_data   (ch_data),
        .ch_flags  (ch_flags),
        .en        (en),
        .data_rd   (data_rd),
        .clr_wr    (clr_wr),
        .clr_mask  (clr_mask),
        .start_wr  (start_wr),
        .stop_wr   (stop_wr),
        .ch_mask   (ch_mask),
        .bus_rdata (bus_rdata)
    );

    rxsc_enable #(
        .NUM_CH (NUM_CH)
    ) u_enable (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .stop_wr  (stop_wr),
        .mask     (ch_mask),
        .en_o     (en)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
        rxsc_chan #(
            .DATA_W (DATA_W)
        ) u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en[c]),
            .rx_done  (rx_done[c]),
            .rx_byte  (rx_byte[c*DATA_W +: DATA_W]),
            .rx_perr  (rx_perr[c]),
            .rx_ferr  (rx_ferr[c]),
            .data_rd  (data_rd[c]),
            .clr_wr   (clr_wr[c]),
            .clr_mask (clr_mask),
            .data_o   (ch_data[c]),
            .flags_o  (ch_flags[c])
        );
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (en == '0 && bus_rdata == '0));

endmodule

// File: tb/tb_uart_rx_status_ctrl.sv
`timescale 1ns/1ps
module tb_uart_rx_status_ctrl;

    localparam int NCH = 4;
    localparam int DW  = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NCH-1:0]    rx_done = '0;
    logic [NCH*DW-1:0] rx_byte = '0;
    logic [NCH-1:0]    rx_perr = '0;
    logic [NCH-1:0]    rx_ferr = '0;
    logic          bus_rd = 1'b0;
    logic          bus_wr = 1'b0;
    logic [4:0]    bus_addr = '0;
    logic [7:0]    bus_wdata = '0;
    logic [7:0]    bus_rdata;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    uart_rx_status_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rx_done(rx_done), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    // ---------------- behavioural reference ----------------
    int m_data [NCH];
    bit m_bff [NCH];
    bit m_perr[NCH];
    bit m_ferr[NCH];
    bit m_ovr [NCH];
    bit m_en  [NCH];
    int m_rd;

    function automatic int model_read(input logic [4:0] a);
        int ch;
        ch = int'(a[3:2]);
        if (a[4]) begin
            if (a[1:0] == 2'd2) begin
                int v = 0;
                for (int i = 0; i < NCH; i++) if (m_en[i]) v += (1 << i);
                return v;
            end
            return 0;
        end
        if (a[1:0] == 2'd0) return m_data[ch];
        if (a[1:0] == 2'd1)
            return int'(m_perr[ch]) + 2 * int'(m_ferr[ch]) + 4 * int'(m_ovr[ch]) + 8 * int'(m_bff[ch]);
        return 0;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NCH; i++) begin
                m_data[i] = 0; m_bff[i] = 0; m_perr[i] = 0;
                m_ferr[i] = 0; m_ovr[i] = 0; m_en[i] = 0;
            end
            m_rd = 0;
        end else begin
            if (bus_rd) m_rd = model_read(bus_addr);
            for (int i = 0; i < NCH; i++) begin
                bit was_full;
                bit rd_here;
                was_full = m_bff[i];
                rd_here  = bus_rd && !bus_addr[4] && int'(bus_addr[3:2]) == i && bus_addr[1:0] == 2'd0;
                if (bus_wr && !bus_addr[4] && int'(bus_addr[3:2]) == i && bus_addr[1:0] == 2'd2) begin
                    if (bus_wdata[0]) m_perr[i] = 0;
                    if (bus_wdata[1]) m_ferr[i] = 0;
                    if (bus_wdata[2]) m_ovr[i]  = 0;
                end
                if (rd_here) m_bff[i] = 0;
                if (m_en[i] && rx_done[i]) begin
                    if (was_full && !rd_here) m_ovr[i] = 1;
                    m_bff[i]  = 1;
                    m_data[i] = int'(rx_byte[i*DW +: DW]);
                    if (rx_perr[i]) m_perr[i] = 1;
                    if (rx_ferr[i]) m_ferr[i] = 1;
                end
            end
            if (bus_wr && bus_addr[4] && bus_addr[1:0] == 2'd0)
                for (int i = 0; i < NCH; i++) if (bus_wdata[i]) m_en[i] = 1;
            if (bus_wr && bus_addr[4] && bus_addr[1:0] == 2'd1)
                for (int i = 0; i < NCH; i++) if (bus_wdata[i]) m_en[i] = 0;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // Every-cycle comparison of registered read data against the model
    always @(negedge clk) begin
        if (running) chk("R2 model compare", int'(bus_rdata), m_rd);
    end

    // ---------------- stimulus helpers ----------------
    function automatic logic [4:0] ca(input int ch, input int off);
        return {1'b0, 2'(ch), 2'(off)};
    endfunction
    function automatic logic [4:0] ga(input int off);
        return {1'b1, 2'b00, 2'(off)};
    endfunction

    task automatic put_rd(input logic [4:0] a);
        bus_rd = 1'b1; bus_addr = a;
    endtask
    task automatic put_wr(input logic [4:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    endtask
    task automatic put_rx(input int ch, input logic [7:0] b, input bit p, input bit f);
        rx_done[ch] = 1'b1; rx_byte[ch*DW +: DW] = b; rx_perr[ch] = p; rx_ferr[ch] = f;
    endtask
    task automatic step();
        @(negedge clk);
        bus_rd = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
        rx_done = '0; rx_perr = '0; rx_ferr = '0;
    endtask
    task automatic rd_chk(input logic [4:0] a, input int exp, input string tag);
        put_rd(a); step(); chk(tag, int'(bus_rdata), exp);
    endtask
    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        put_wr(a, d); step();
    endtask
    task automatic rx(input int ch, input logic [7:0] b, input bit p, input bit f);
        put_rx(ch, b, p, f); step();
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int saved;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        running = 1'b1;

        chk("R1 rdata after reset", int'(bus_rdata), 0);
        rd_chk(ca(0, 1), 0, "R1 status ch0 after reset");
        rd_chk(ga(2), 0, "R1 enable after reset");

        rx(0, 8'hA5, 1, 1);
        rd_chk(ca(0, 1), 0, "R11 stopped ch0 status");
        rd_chk(ca(0, 0), 0, "R11 stopped ch0 data");

        wr(ga(0), 8'h05);
        rd_chk(ga(2), 8'h05, "R9 start ch0 ch2");
        wr(ga(0), 8'h02);
        rd_chk(ga(2), 8'h07, "R9 start keeps others");
        wr(ga(1), 8'h02);
        rd_chk(ga(2), 8'h05, "R10 stop ch1");
        rd_chk(ga(0), 0, "R12 start reads zero");
        rd_chk(ga(1), 0, "R12 stop reads zero");
        rd_chk(ga(3), 0, "R12 unused offset");

        rx(0, 8'h3C, 0, 0);
        rd_chk(ca(0, 1), 8'h08, "R2 bff after strobe");
        rd_chk(ca(0, 0), 8'h3C, "R3 data read");
        rd_chk(ca(0, 1), 8'h00, "R3 bff cleared by read");

        rx(2, 8'h11, 0, 0);
        rx(2, 8'h22, 0, 0);
        rd_chk(ca(2, 1), 8'h0C, "R4 overrun raised");
        rd_chk(ca(2, 0), 8'h22, "R4 new byte replaces");
        rd_chk(ca(2, 1), 8'h04, "R4 overrun stays after read");

        wr(ca(2, 2), 8'h00);
        rd_chk(ca(2, 1), 8'h04, "R6 zero write no effect");
        wr(ca(2, 2), 8'h04);
        rd_chk(ca(2, 1), 8'h00, "R6 overrun cleared");
        rx(2, 8'h33, 0, 0);
        wr(ca(2, 2), 8'h08);
        rd_chk(ca(2, 1), 8'h08, "R6 bit3 ignored");
        rd_chk(ca(2, 2), 0, "R12 clear trigger reads zero");
        rd_chk(ca(2, 0), 8'h33, "R3 data ch2");

        rx(0, 8'h7E, 1, 1);
        rd_chk(ca(0, 1), 8'h0B, "R5 parity framing bff layout");
        rd_chk(ca(0, 0), 8'h7E, "R2 data with errors");
        put_rd(ca(0, 1)); step();
        saved = int'(bus_rdata);
        chk("R5 errors only", saved, 8'h03);
        rx(0, 8'h01, 0, 0);
        rx(0, 8'h02, 0, 0);
        rd_chk(ca(0, 1), 8'h0F, "R4 all flags");
        wr(ca(0, 2), 8'(saved));
        rd_chk(ca(0, 1), 8'h0C, "R7 later overrun kept");
        wr(ca(0, 2), 8'h07);
        rd_chk(ca(0, 0), 8'h02, "R3 data ch0");
        rd_chk(ca(0, 1), 8'h00, "R6 all cleared");

        rx(2, 8'h44, 1, 0);
        rd_chk(ca(2, 1), 8'h09, "R2 parity set");
        put_wr(ca(2, 2), 8'h01); put_rx(2, 8'h55, 1, 0); step();
        rd_chk(ca(2, 1), 8'h0D, "R8 set wins over clear");
        wr(ca(2, 2), 8'h07);
        rd_chk(ca(2, 1), 8'h08, "R6 errors cleared ch2");
        put_rd(ca(2, 0)); put_rx(2, 8'h66, 0, 0); step();
        chk("R3 read returns old byte", int'(bus_rdata), 8'h55);
        rd_chk(ca(2, 1), 8'h08, "R3 no overrun on read collision");

        wr(ga(1), 8'h04);
        rd_chk(ga(2), 8'h01, "R10 stop ch2");
        rx(2, 8'h77, 1, 1);
        rd_chk(ca(2, 1), 8'h08, "R10 R11 flags kept while stopped");
        rd_chk(ca(2, 0), 8'h66, "R11 byte kept while stopped");
        wr(ga(0), 8'h04);
        rd_chk(ga(2), 8'h05, "R9 restart ch2");
        rx(2, 8'h88, 0, 0);
        rd_chk(ca(2, 0), 8'h88, "R9 receives after restart");
        rd_chk(ca(3, 1), 0, "R11 ch3 never started");

        repeat (4) @(negedge clk);
        running = 1'b0;
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule